// File: doc/BRIEF.md
# Timer Interrupt Router

This block takes the fire strobes of a set of timer channels and turns each into an interrupt on one line of a wide interrupt vector. Every channel has a configuration word. A five-bit field in that word names the destination line, and a single bit enables the channel. A global enable gates every channel at once.

A legacy routing input changes where the first two channels go. When it is set, channel 0 always lands on line 0 and channel 1 always lands on line 8, and their route fields are ignored. All higher channels keep following their route fields in both modes.

Delivery is edge-style. A rising edge on a fire strobe, seen while both enables are on, produces a one-cycle pulse on the selected line in the following cycle. A fire that arrives while delivery is gated off is lost; it is not held back for later. The block also drives, for every channel, a fixed capability word that lists the lines software may choose.

Top module: `timer_irq_router`

## Requirements
- R1: With `legacy_i` = 1, a delivered fire of timer 0 pulses line 0 and a delivered fire of timer 1 pulses line 8, whatever their route fields hold.
- R2: With `legacy_i` = 0 for every timer, and with either value of `legacy_i` for timers 2 and higher, a delivered fire pulses exactly the line whose number is in configuration bits [13:9] of that timer.
- R3: A fire is delivered only if configuration bit 2 of its timer and `glb_en_i` are both 1 in the cycle of the fire's rising edge. Otherwise it is dropped: no pulse then and none later, including when the enables come on while the strobe is still high.
- R4: A delivered fire gives a pulse of exactly one cycle, in the cycle after the strobe's rising edge. A strobe held high for several cycles gives one pulse.
- R5: Timers that fire in the same cycle onto the same line give one single-cycle pulse on that line. Timers that fire onto different lines each pulse their own line in the same cycle.
- R6: `cap_o` carries the word 0x00000C20 for every timer (bits 5, 10 and 11 set: lines 5, 10 and 11 allowed), timer i in bits [32*i+31:32*i].
- R7: During reset and in the first cycle after it, `irq_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| fire_i | input | 3 | Per-timer fire strobes, bit i is timer i |
| cfg_i | input | 96 | Per-timer configuration words, timer i in [32*i+31:32*i]; bit 2 enable, bits [13:9] route |
| glb_en_i | input | 1 | Global interrupt enable |
| legacy_i | input | 1 | Legacy fixed routing for timers 0 and 1 |
| irq_o | output | 32 | Interrupt line vector, one-cycle pulses |
| cap_o | output | 96 | Per-timer allowed-line capability words |

## Verification
Every pulse on `irq_o` is due exactly one clock after the edge that samples the strobe's rising edge. The enables and route fields sampled at that same edge decide the pulse. The bench changes its inputs on the falling edge. It checks the whole vector on the next falling edge, and again one cycle later to show that the pulse has ended. The held-strobe and gated-off cases are instead watched over several following cycles, so that a late or repeated pulse would also be counted. `cap_o` and the reset value are constant, and are read directly during and after reset.

// File: rtl/tir_pkg.sv
package tir_pkg;
   // default field placement inside a timer configuration word
   localparam int unsigned DEF_CFG_W     = 32;
   localparam int unsigned DEF_ROUTE_LSB = 9;
   localparam int unsigned DEF_ROUTE_W   = 5;
   localparam int unsigned DEF_EN_BIT    = 2;
   // default fixed lines used in legacy routing
   localparam int unsigned DEF_LEG_LINE0 = 0;
   localparam int unsigned DEF_LEG_LINE1 = 8;
   // default advertised line set: lines 5, 10, 11
   localparam logic [31:0] DEF_CAP_MASK  = 32'h0000_0C20;

   // fixed legacy line for a channel index
   function automatic int unsigned leg_line(input int unsigned idx,
                                            input int unsigned l0,
                                            input int unsigned l1);
      return (idx == 0) ? l0 : l1;
   endfunction
endpackage

// File: rtl/tir_fire_edge.sv
module tir_fire_edge #(
   parameter int unsigned N = 3
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [N-1:0] fire_i,
   output logic [N-1:0] rise_o
);
   logic [N-1:0] fire_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) fire_q <= '0;
      else         fire_q <= fire_i;
   end

   assign rise_o = fire_i & ~fire_q;

   generate
      for (genvar i = 0; i < N; i++) begin : g_chk
         // a rising edge can never be seen in two cycles in a row
         assert_rise_single_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
            rise_o[i] |=> !rise_o[i]);
      end
   endgenerate
endmodule

// File: rtl/tir_route_sel.sv
module tir_route_sel #(
   parameter int unsigned IDX        = 0,
   parameter int unsigned CFG_W      = 32,
   parameter int unsigned NUM_LINES  = 32,
   parameter int unsigned ROUTE_LSB  = 9,
   parameter int unsigned ROUTE_W    = 5,
   parameter int unsigned EN_BIT     = 2,
   parameter bit          HAS_LEGACY = 1'b0,
   parameter int unsigned LEG_LINE   = 0
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 rise_i,
   input  logic [CFG_W-1:0]     cfg_i,
   input  logic                 glb_en_i,
   input  logic                 legacy_i,
   output logic [NUM_LINES-1:0] hit_o
);
   localparam int unsigned ROUTE_MSB = ROUTE_LSB + ROUTE_W - 1;

   generate
      if (ROUTE_MSB >= CFG_W) begin : g_bad_route
         $error("route field outside configuration word");
      end
      if (EN_BIT >= CFG_W) begin : g_bad_en
         $error("enable bit outside configuration word");
      end
      if (HAS_LEGACY && LEG_LINE >= NUM_LINES) begin : g_bad_leg
         $error("legacy line outside interrupt vector");
      end
   endgenerate

   logic [ROUTE_W-1:0] route;
   logic               deliver;
   int unsigned        sel;

   assign route   = cfg_i[ROUTE_MSB:ROUTE_LSB];
   assign deliver = rise_i & cfg_i[EN_BIT] & glb_en_i;

   // destination choice: legacy channels have a fixed-line variant
   generate
      if (HAS_LEGACY) begin : g_leg
         always_comb begin
            if (legacy_i) sel = LEG_LINE;
            else          sel = int'(route);
         end
      end else begin : g_plain
         logic unused_leg;
         assign unused_leg = legacy_i;
         always_comb sel = int'(route);
      end
   endgenerate

   // one-hot decode of the destination, dropped when gated
   generate
      for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
         assign hit_o[l] = deliver && (sel == l);
      end
   endgenerate

   assert_one_line_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(hit_o));
   assert_gated_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!glb_en_i || !cfg_i[EN_BIT] || !rise_i) |-> (hit_o == '0));
endmodule

// File: rtl/tir_line_merge.sv
module tir_line_merge #(
   parameter int unsigned NUM_TIMERS = 3,
   parameter int unsigned NUM_LINES  = 32
) (
   input  logic                            clk_i,
   input  logic                            rst_ni,
   input  logic [NUM_TIMERS*NUM_LINES-1:0] hits_i,
   output logic [NUM_LINES-1:0]            irq_o
);
   logic [NUM_LINES-1:0] merged;
   logic [NUM_LINES-1:0] irq_q;

   always_comb begin
      merged = '0;
      for (int t = 0; t < NUM_TIMERS; t++) begin
         merged = merged | hits_i[t*NUM_LINES +: NUM_LINES];
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) irq_q <= '0;
      else         irq_q <= merged;
   end

   assign irq_o = irq_q;

   assert_merge_R5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|hits_i) |=> (|irq_o));
   assert_quiet_R5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hits_i == '0) |=> (irq_o == '0));
endmodule

// File: rtl/timer_irq_router.sv
module timer_irq_router
   import tir_pkg::*;
#(
   parameter int unsigned NUM_TIMERS    = 3,
   parameter int unsigned NUM_LINES     = 32,
   parameter int unsigned CFG_W         = DEF_CFG_W,
   parameter int unsigned ROUTE_LSB     = DEF_ROUTE_LSB,
   parameter int unsigned ROUTE_W       = DEF_ROUTE_W,
   parameter int unsigned EN_BIT        = DEF_EN_BIT,
   parameter int unsigned LEGACY_TIMERS = 2,
   parameter int unsigned LEG_LINE0     = DEF_LEG_LINE0,
   parameter int unsigned LEG_LINE1     = DEF_LEG_LINE1,
   parameter int unsigned CAP_W         = 32,
   parameter logic [CAP_W-1:0] CAP_MASK = CAP_W'(DEF_CAP_MASK)
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic [NUM_TIMERS-1:0]       fire_i,
   input  logic [NUM_TIMERS*CFG_W-1:0] cfg_i,
   input  logic                        glb_en_i,
   input  logic                        legacy_i,
   output logic [NUM_LINES-1:0]        irq_o,
   output logic [NUM_TIMERS*CAP_W-1:0] cap_o
);
   localparam int unsigned HITS_W = NUM_TIMERS * NUM_LINES;

   generate
      if (NUM_LINES < 24) begin : g_bad_lines
         $error("interrupt vector must have at least 24 lines");
      end
      if (NUM_TIMERS < 1) begin : g_bad_timers
         $error("at least one timer required");
      end
      if (LEGACY_TIMERS > 2 || LEGACY_TIMERS > NUM_TIMERS) begin : g_bad_leg
         $error("legacy routing covers at most two existing timers");
      end
   endgenerate

   logic [NUM_TIMERS-1:0] rise_w;
   logic [HITS_W-1:0]     hits_w;

   tir_fire_edge #(
      .N(NUM_TIMERS)
   ) u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .fire_i (fire_i),
      .rise_o (rise_w)
   );

   generate
      for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_tmr
         tir_route_sel #(
            .IDX        (i),
            .CFG_W      (CFG_W),
            .NUM_LINES  (NUM_LINES),
            .ROUTE_LSB  (ROUTE_LSB),
            .ROUTE_W    (ROUTE_W),
            .EN_BIT     (EN_BIT),
            .HAS_LEGACY (i < LEGACY_TIMERS),
            .LEG_LINE   (leg_line(i, LEG_LINE0, LEG_LINE1))
         ) u_sel (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .rise_i   (rise_w[i]),
            .cfg_i    (cfg_i[i*CFG_W +: CFG_W]),
            .glb_en_i (glb_en_i),
            .legacy_i (legacy_i),
            .hit_o    (hits_w[i*NUM_LINES +: NUM_LINES])
         );
         assign cap_o[i*CAP_W +: CAP_W] = CAP_MASK;
      end
   endgenerate

   tir_line_merge #(
      .NUM_TIMERS (NUM_TIMERS),
      .NUM_LINES  (NUM_LINES)
   ) u_merge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .hits_i (hits_w),
      .irq_o  (irq_o)
   );

   assert_global_gate_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !glb_en_i |=> (irq_o == '0));
   assert_legacy_t0_R1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (legacy_i && glb_en_i && cfg_i[EN_BIT] && rise_w[0]) |=> irq_o[LEG_LINE0]);
   assert_no_fire_no_irq_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rise_w == '0) |=> (irq_o == '0));
endmodule

// File: tb/test_timer_irq_router.sv
module test_timer_irq_router;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  fire = '0;
   logic [95:0] cfg = '0;
   logic        glb = 1'b0;
   logic        leg = 1'b0;
   logic [31:0] irq;
   logic [95:0] cap;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   timer_irq_router i_timer_irq_router (
      .clk_i    (clk),
      .rst_ni   (rst_n),
      .fire_i   (fire),
      .cfg_i    (cfg),
      .glb_en_i (glb),
      .legacy_i (leg),
      .irq_o    (irq),
      .cap_o    (cap)
   );

   // vector: [63:61] fire, [60:58] timer enables, [57:53] route2,
   // [52:48] route1, [47:43] route0, [42] global, [41] legacy, [31:0] expected
   localparam int NV = 12;
   localparam logic [63:0] VEC [NV] = '{
      {3'b001, 3'b111, 5'd0,  5'd0,  5'd3,  1'b1, 1'b0, 9'd0, 32'h0000_0008},
      {3'b010, 3'b111, 5'd0,  5'd17, 5'd0,  1'b1, 1'b0, 9'd0, 32'h0002_0000},
      {3'b100, 3'b111, 5'd31, 5'd0,  5'd0,  1'b1, 1'b1, 9'd0, 32'h8000_0000},
      {3'b001, 3'b111, 5'd0,  5'd0,  5'd5,  1'b1, 1'b1, 9'd0, 32'h0000_0001},
      {3'b010, 3'b111, 5'd0,  5'd10, 5'd0,  1'b1, 1'b1, 9'd0, 32'h0000_0100},
      {3'b111, 3'b111, 5'd11, 5'd10, 5'd5,  1'b1, 1'b0, 9'd0, 32'h0000_0C20},
      {3'b111, 3'b111, 5'd22, 5'd21, 5'd20, 1'b1, 1'b1, 9'd0, 32'h0040_0101},
      {3'b101, 3'b111, 5'd7,  5'd0,  5'd7,  1'b1, 1'b0, 9'd0, 32'h0000_0080},
      {3'b111, 3'b111, 5'd3,  5'd4,  5'd5,  1'b0, 1'b0, 9'd0, 32'h0000_0000},
      {3'b111, 3'b010, 5'd2,  5'd4,  5'd1,  1'b1, 1'b0, 9'd0, 32'h0000_0010},
      {3'b011, 3'b111, 5'd9,  5'd3,  5'd6,  1'b1, 1'b1, 9'd0, 32'h0000_0101},
      {3'b111, 3'b111, 5'd0,  5'd2,  5'd4,  1'b1, 1'b1, 9'd0, 32'h0000_0101}
   };
   localparam string VTAG [NV] = '{"R2", "R2", "R2", "R1", "R1", "R5",
                                   "R1", "R5", "R3", "R3", "R1", "R5"};

   function automatic logic [31:0] mk_cfg(input logic en, input logic [4:0] rt);
      mk_cfg = '0;
      mk_cfg[2]    = en;
      mk_cfg[13:9] = rt;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: irq actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #200000;
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin
      int pulses;
      // reset state: R7, capability: R6
      repeat (3) @(negedge clk);
      check("R7 in reset", irq, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R7 after reset", irq, 32'h0);
      for (int i = 0; i < 3; i++) begin
         check("R6 capability", cap[i*32 +: 32], 32'h0000_0C20);
      end

      // table walk: pulse due one cycle after the rising edge, gone the next
      for (int v = 0; v < NV; v++) begin
         cfg[31:0]  = mk_cfg(VEC[v][58], VEC[v][47:43]);
         cfg[63:32] = mk_cfg(VEC[v][59], VEC[v][52:48]);
         cfg[95:64] = mk_cfg(VEC[v][60], VEC[v][57:53]);
         glb  = VEC[v][42];
         leg  = VEC[v][41];
         fire = VEC[v][63:61];
         @(negedge clk);
         check(VTAG[v], irq, VEC[v][31:0]);
         fire = '0;
         @(negedge clk);
         check("R4 pulse ends", irq, 32'h0);
      end

      // R4: strobe held high gives one pulse, in the cycle after the edge
      cfg[31:0] = mk_cfg(1'b1, 5'd12);
      glb = 1'b1;
      leg = 1'b0;
      fire = 3'b001;
      @(negedge clk);
      check("R4 pulse timing", irq, 32'h0000_1000);
      pulses = 1;
      for (int c = 0; c < 5; c++) begin
         @(negedge clk);
         if (irq != 0) pulses++;
      end
      check("R4 held strobe single pulse", 32'(pulses), 32'd1);
      fire = '0;
      @(negedge clk);

      // R3: dropped while global enable off, no pulse once enabled
      glb = 1'b0;
      fire = 3'b001;
      @(negedge clk);
      check("R3 gated global", irq, 32'h0);
      glb = 1'b1;
      pulses = 0;
      for (int c = 0; c < 4; c++) begin
         @(negedge clk);
         if (irq != 0) pulses++;
      end
      check("R3 no late pulse global", 32'(pulses), 32'd0);
      fire = '0;
      @(negedge clk);

      // R3: dropped while timer enable off, no pulse once enabled
      cfg[31:0] = mk_cfg(1'b0, 5'd12);
      fire = 3'b001;
      @(negedge clk);
      check("R3 gated timer", irq, 32'h0);
      cfg[31:0] = mk_cfg(1'b1, 5'd12);
      pulses = 0;
      for (int c = 0; c < 4; c++) begin
         @(negedge clk);
         if (irq != 0) pulses++;
      end
      check("R3 no late pulse timer", 32'(pulses), 32'd0);
      fire = '0;
      @(negedge clk);

      // R1: legacy toggled between fires of timer 1
      cfg[63:32] = mk_cfg(1'b1, 5'd23);
      leg = 1'b1;
      fire = 3'b010;
      @(negedge clk);
      check("R1 legacy timer1", irq, 32'h0000_0100);
      fire = '0;
      leg = 1'b0;
      @(negedge clk);
      fire = 3'b010;
      @(negedge clk);
      check("R2 legacy off timer1", irq, 32'h0080_0000);
      fire = '0;
      @(negedge clk);
      check("R4 final idle", irq, 32'h0);

      finish_run();
   end
endmodule